// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Guard

This block keeps the status byte of a serial flash and decides, one command at a time, whether a write-type request may reach the array. A command decoder that sits upstream presents a complete, already-deserialized command: an opcode, an address and a data byte. The block then answers with a single-cycle grant or refusal. A grant starts the array operation and marks the device busy. The array sequencer later returns a completion pulse, which clears the busy flag and, when the rules call for it, the write-enable latch.

The status byte holds the busy flag, the write-enable latch, a three-bit protection level, the word-stream programming flag and a lock-down flag. The protection level marks the top 1/32, 1/16, 1/8, 1/4 or 1/2 of the array, the whole array, or nothing. Program and erase requests are judged against the full region they touch. A status write needs an arming command directly before it. The external protect input together with the lock-down flag decides whether a status write may change anything. Word-stream programming keeps its own address pointer. It leaves the mode once the next word would land in protected space or past the top of the array.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte reads 0x1C: bits 4:2 (protection level) are 111, and bit 0 (busy), bit 1 (write enable), bit 6 (word stream) and bit 7 (lock-down) are 0.
- R2: Opcode 06h sets bit 1. Opcode 04h clears bit 1 and bit 6.
- R3: Opcode 01h (status write) acts only when the previous command was 50h or 06h. Any other command in between cancels the arming, and a 06h in between arms again. A status write that acts clears bit 1.
- R4: A status write copies only data bits 4:2 and bit 7 into the status byte. Data bits 0, 1, 5 and 6 have no effect, and status bit 5 always reads 0.
- R5: With the protect input low (wrProtN=0) and bit 7 set, a status write changes nothing. With the input low and bit 7 clear, one write may set bit 7 and change bits 4:2 together. With the input high, every writable bit may be changed, including clearing bit 7.
- R6: Level codes in bits 4:2 protect these ranges: 001 from 1F0000h, 010 from 1E0000h, 011 from 1C0000h, 100 from 180000h, 101 from 100000h, each running up to 1FFFFFh. Codes 110 and 111 protect the whole array, and 000 protects nothing.
- R7: Byte program (02h), sector erase (20h), block erase (D8h), chip erase (60h or C7h) and word stream (ADh) are refused unless bit 1 is set. A refused command leaves the status byte unchanged.
- R8: Sector erase judges the 4 KiB region selected by address bits 20:12, and block erase judges the 64 KiB region selected by bits 20:16. The request is refused if any byte of that region is protected.
- R9: Chip erase is granted only when bits 4:2 are 000.
- R10: A grant sets bit 0. The completion pulse clears bit 0, and outside word-stream mode it also clears bit 1. While bit 0 is set, every program, erase and status-write request is refused.
- R11: The first ADh command starts at its address with bit 0 forced to 0, and each following ADh takes the next word address. Bit 6 is set while the mode lasts. A completion in the mode keeps bit 1. Byte program, erases and status writes are refused while bit 6 is set.
- R12: At a completion in word-stream mode, if the next word address is protected or lies past 1FFFFFh, bits 6 and 1 are cleared.
- R13: The grant and refusal outputs are one-cycle pulses in the cycle after the command and are never high together. opAddr carries the granted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdOp | input | 8 | Command opcode |
| cmdAddr | input | 21 | Command byte address |
| cmdData | input | 8 | Data byte for a status write |
| wrProtN | input | 1 | External protect input, low enables lock-down |
| opDone | input | 1 | Completion pulse from the array sequencer |
| statusByte | output | 8 | Current status byte |
| opGrant | output | 1 | Array operation granted (one cycle) |
| opRefuse | output | 1 | Write-type command refused (one cycle) |
| opAddr | output | 21 | Address of the last granted operation |

## Verification
The bench targets the protection edges. It places a byte one below and at each protection base, and it gives sector and block erases unaligned addresses whose region just clears or just meets the base. A design that judged only the raw address, or decoded the wrong address bits, would grant or refuse the wrong side of the line. It breaks the arming with a status read, then re-arms with a second write-enable: a design that latched the arming forever, or lost it on re-arming, would mis-write the status byte. The word stream is run up to the protected base and to the very top of the array. A pointer that skipped the exit check, or wrapped, would keep the mode alive with write enable still set. The bench also tries to clear the lock-down bit with the protect input low, and a design that ignored that input would unlock the level bits.

// File: rtl/flashsr_pkg.sv
package flashsr_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_EWSR  = 8'h50;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_WORD  = 8'hAD;
  localparam logic [7:0] OP_SECT  = 8'h20;
  localparam logic [7:0] OP_BLK   = 8'hD8;
  localparam logic [7:0] OP_CHIPA = 8'h60;
  localparam logic [7:0] OP_CHIPB = 8'hC7;

  localparam int BP_W = 3;

  // status bits a status write may change: 7 and 4:2
  localparam logic [7:0] SR_WR_MASK = 8'b1001_1100;

  typedef enum logic [2:0] {
    K_NONE, K_BYTE, K_WORD, K_SECT, K_BLK, K_CHIP
  } kind_t;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic clrAai;
    logic writeSr;
    logic startOp;
    logic startAai;
    logic stepAai;
    logic refuse;
  } strobe_t;

endpackage

// File: rtl/flashsr_range.sv
module flashsr_range
  import flashsr_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 16,
  parameter int LEVELS = 5
) (
  input  logic [BP_W-1:0]   bpLevel,
  input  kind_t             kind,
  input  logic [ADDR_W-1:0] checkAddr,
  output logic              hit,
  output logic              anyProt,
  output logic [ADDR_W-1:0] protBase
);

  localparam logic [ADDR_W-1:0] ONES      = '1;
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECT_W) - 1);
  localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((1 << BLK_W) - 1);
  localparam int SHIFT0 = ADDR_W - LEVELS - 1;

  logic [ADDR_W-1:0] regionHi;

  // lowest protected address for the current level
  always_comb begin
    anyProt = (bpLevel != '0);
    if (bpLevel == '0)
      protBase = ONES;
    else if (int'(bpLevel) <= LEVELS)
      protBase = ONES << (SHIFT0 + int'(bpLevel));
    else
      protBase = '0;
  end

  // highest address touched by the request; protection runs to the top,
  // so the region overlaps it exactly when its top reaches the base
  always_comb begin
    case (kind)
      K_WORD:  regionHi = checkAddr | ADDR_W'(1);
      K_SECT:  regionHi = checkAddr | SECT_MASK;
      K_BLK:   regionHi = checkAddr | BLK_MASK;
      default: regionHi = checkAddr;
    endcase
    if (kind == K_CHIP)
      hit = anyProt;
    else
      hit = anyProt && (regionHi >= protBase);
  end

endmodule

// File: rtl/flashsr_ctrl.sv
module flashsr_ctrl
  import flashsr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdOp,
  input  logic       wrProtN,
  input  logic       busy,
  input  logic       wel,
  input  logic       aai,
  input  logic       bpl,
  input  logic       hit,
  output kind_t      kind,
  output strobe_t    st
);

  logic armed;
  logic isWrite;

  always_comb begin
    case (cmdOp)
      OP_PROG:            kind = K_BYTE;
      OP_WORD:            kind = K_WORD;
      OP_SECT:            kind = K_SECT;
      OP_BLK:             kind = K_BLK;
      OP_CHIPA, OP_CHIPB: kind = K_CHIP;
      default:            kind = K_NONE;
    endcase
  end

  assign isWrite = (kind != K_NONE);

  always_comb begin
    st = '0;
    if (cmdValid) begin
      if (cmdOp == OP_WREN) st.setWel = 1'b1;
      if (cmdOp == OP_WRDI) begin
        st.clrWel = 1'b1;
        st.clrAai = 1'b1;
      end
      if (cmdOp == OP_WRSR) begin
        if (!busy && !aai && armed && (wrProtN || !bpl)) st.writeSr = 1'b1;
        else                                             st.refuse  = 1'b1;
      end
      if (isWrite) begin
        if (!wel || busy || hit)      st.refuse   = 1'b1;
        else if (kind == K_WORD)
          if (aai)                    st.stepAai  = 1'b1;
          else                        st.startAai = 1'b1;
        else if (aai)                 st.refuse   = 1'b1;
        else                          st.startOp  = 1'b1;
      end
    end
  end

  // arming lasts exactly until the next command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         armed <= 1'b0;
    else if (cmdValid) armed <= (cmdOp == OP_EWSR) || (cmdOp == OP_WREN);
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.startOp, st.startAai, st.stepAai, st.writeSr, st.refuse})); // R13

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (st == '0)); // R13

endmodule

// File: rtl/flashsr_dp.sv
module flashsr_dp
  import flashsr_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  kind_t             kind,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              wrProtN,
  input  logic              opDone,
  input  logic              anyProt,
  input  logic [ADDR_W-1:0] protBase,
  output logic [ADDR_W-1:0] checkAddr,
  output logic [7:0]        statusByte,
  output logic              busy,
  output logic              wel,
  output logic              aai,
  output logic              bpl,
  output logic [BP_W-1:0]   bpLevel,
  output logic              opGrant,
  output logic              opRefuse,
  output logic [ADDR_W-1:0] opAddr
);

  logic [ADDR_W:0]   wordPtr;
  logic [ADDR_W:0]   ptrNext;
  logic              aaiExit;
  logic [7:0]        srNext;

  assign statusByte = {bpl, aai, 1'b0, bpLevel, wel, busy};
  assign srNext     = (cmdData & SR_WR_MASK) | (statusByte & ~SR_WR_MASK);

  always_comb begin
    if (kind == K_WORD)
      checkAddr = aai ? wordPtr[ADDR_W-1:0] : {cmdAddr[ADDR_W-1:1], 1'b0};
    else
      checkAddr = cmdAddr;
  end

  assign ptrNext = {1'b0, checkAddr} + (ADDR_W+1)'(2);
  assign aaiExit = wordPtr[ADDR_W] || (anyProt && (wordPtr[ADDR_W-1:0] >= protBase));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      wel      <= 1'b0;
      aai      <= 1'b0;
      bpl      <= 1'b0;
      bpLevel  <= '1;
      wordPtr  <= '0;
      opGrant  <= 1'b0;
      opRefuse <= 1'b0;
      opAddr   <= '0;
    end else begin
      opGrant  <= 1'b0;
      opRefuse <= st.refuse;
      if (opDone && busy) begin
        busy <= 1'b0;
        if (!aai) wel <= 1'b0;
        else if (aaiExit) begin
          aai <= 1'b0;
          wel <= 1'b0;
        end
      end
      if (st.setWel) wel <= 1'b1;
      if (st.clrWel) wel <= 1'b0;
      if (st.clrAai) aai <= 1'b0;
      if (st.writeSr) begin
        bpLevel <= srNext[4:2];
        bpl     <= srNext[7];
        wel     <= 1'b0;
      end
      if (st.startOp || st.startAai || st.stepAai) begin
        busy    <= 1'b1;
        opGrant <= 1'b1;
        opAddr  <= checkAddr;
      end
      if (st.startAai || st.stepAai) begin
        aai     <= 1'b1;
        wordPtr <= ptrNext;
      end
    end
  end

  AST_NO_GRANT_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    !(opGrant && opRefuse)); // R13

  AST_BPL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!wrProtN && bpl) |=> bpl); // R5

  AST_BP_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!wrProtN && bpl) |=> $stable(bpLevel)); // R5

  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    opGrant |-> $past(wel)); // R7

  AST_GRANT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    opGrant |-> busy); // R10

  AST_AAI_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    aai |-> wel); // R11

  AST_CHIP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (st.startOp && kind == K_CHIP) |-> (bpLevel == '0)); // R9

endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import flashsr_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 16,
  parameter int LEVELS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              wrProtN,
  input  logic              opDone,
  output logic [7:0]        statusByte,
  output logic              opGrant,
  output logic              opRefuse,
  output logic [ADDR_W-1:0] opAddr
);

  kind_t             kind;
  strobe_t           st;
  logic              busy, wel, aai, bpl, hit, anyProt;
  logic [BP_W-1:0]   bpLevel;
  logic [ADDR_W-1:0] protBase;
  logic [ADDR_W-1:0] checkAddr;

  flashsr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .wrProtN(wrProtN), .busy(busy), .wel(wel), .aai(aai), .bpl(bpl),
    .hit(hit), .kind(kind), .st(st)
  );

  flashsr_range #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W), .LEVELS(LEVELS)) uRange (
    .bpLevel(bpLevel), .kind(kind), .checkAddr(checkAddr),
    .hit(hit), .anyProt(anyProt), .protBase(protBase)
  );

  flashsr_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .kind(kind), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .wrProtN(wrProtN), .opDone(opDone),
    .anyProt(anyProt), .protBase(protBase), .checkAddr(checkAddr),
    .statusByte(statusByte), .busy(busy), .wel(wel), .aai(aai), .bpl(bpl),
    .bpLevel(bpLevel), .opGrant(opGrant), .opRefuse(opRefuse), .opAddr(opAddr)
  );

endmodule

// File: tb/flash_status_guard_test.sv
module flash_status_guard_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdOp = 8'h00;
  logic [20:0] cmdAddr = '0;
  logic [7:0]  cmdData = 8'h00;
  logic        wrProtN = 1'b1;
  logic        opDone = 1'b0;
  logic [7:0]  statusByte;
  logic        opGrant, opRefuse;
  logic [20:0] opAddr;

  flash_status_guard uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .wrProtN(wrProtN), .opDone(opDone),
    .statusByte(statusByte), .opGrant(opGrant), .opRefuse(opRefuse), .opAddr(opAddr)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [31:0] due;
    logic [7:0]  st;
    logic        g;
    logic        r;
    logic [20:0] a;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    finished = 0;

  // reference state
  logic [2:0]  mBp = 3'b111;
  logic        mBpl = 0, mWel = 0, mBusy = 0, mAai = 0, mArmed = 0;
  logic [21:0] mPtr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [20:0] mBase(input logic [2:0] bp);
    case (bp)
      3'd1: return 21'h1F0000;
      3'd2: return 21'h1E0000;
      3'd3: return 21'h1C0000;
      3'd4: return 21'h180000;
      3'd5: return 21'h100000;
      default: return 21'h000000;
    endcase
  endfunction

  function automatic bit mHit(input logic [2:0] bp, input logic [20:0] hi);
    return (bp != 3'b000) && (hi >= mBase(bp));
  endfunction

  function automatic logic [7:0] mStatus();
    return {mBpl, mAai, 1'b0, mBp, mWel, mBusy};
  endfunction

  task automatic push(input logic g, input logic r, input logic [20:0] a, input string tag);
    exp_t e;
    e.due = cyc + 1;
    e.st  = mStatus();
    e.g   = g;
    e.r   = r;
    e.a   = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic cmd(input logic [7:0] op, input logic [20:0] addr, input logic [7:0] data,
                     input string tag);
    logic        eG, eR, ok;
    logic [20:0] hi, wa;
    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdAddr = addr; cmdData = data;
    eG = 0; eR = 0; hi = addr; wa = addr;
    case (op)
      8'h06: mWel = 1;
      8'h04: begin mWel = 0; mAai = 0; end
      8'h01: begin
        if (!mBusy && !mAai && mArmed && (wrProtN || !mBpl)) begin
          mBp = data[4:2]; mBpl = data[7]; mWel = 0;
        end else eR = 1;
      end
      8'h02, 8'h20, 8'hD8, 8'h60, 8'hC7: begin
        if (op == 8'h20) hi = {addr[20:12], 12'hFFF};
        if (op == 8'hD8) hi = {addr[20:16], 16'hFFFF};
        ok = mWel && !mBusy && !mAai &&
             ((op == 8'h60 || op == 8'hC7) ? (mBp == 3'b000) : !mHit(mBp, hi));
        if (ok) begin mBusy = 1; eG = 1; end else eR = 1;
      end
      8'hAD: begin
        wa = mAai ? mPtr[20:0] : {addr[20:1], 1'b0};
        ok = mWel && !mBusy && !mHit(mBp, wa | 21'd1);
        if (ok) begin
          mBusy = 1; mAai = 1; eG = 1; mPtr = {1'b0, wa} + 22'd2;
        end else eR = 1;
      end
      default: ;
    endcase
    mArmed = (op == 8'h50) || (op == 8'h06);
    push(eG, eR, wa, tag);
    @(posedge clk); #2;
    cmdValid = 0;
  endtask

  task automatic finishOp(input string tag);
    @(negedge clk);
    opDone = 1;
    if (mBusy) begin
      mBusy = 0;
      if (!mAai) mWel = 0;
      else if (mPtr[21] || mHit(mBp, mPtr[20:0])) begin mAai = 0; mWel = 0; end
    end
    push(1'b0, 1'b0, 21'h0, tag);
    @(posedge clk); #2;
    opDone = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due == cyc) begin
      exp_t  e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (statusByte !== e.st || opGrant !== e.g || opRefuse !== e.r ||
          (e.g && opAddr !== e.a)) begin
        bad++;
        $display("FAIL %s: got status=%h grant=%b refuse=%b addr=%h, expected status=%h grant=%b refuse=%b addr=%h",
                 t, statusByte, opGrant, opRefuse, opAddr, e.st, e.g, e.r, e.a);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (statusByte !== 8'h1C || opGrant !== 1'b0 || opRefuse !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: got status=%h, expected status=1c", statusByte);
    end
    @(negedge clk); rstN = 1;
    total++;
    if (statusByte !== 8'h1C) begin
      bad++;
      $display("FAIL R1 after release: got status=%h, expected status=1c", statusByte);
    end

    cmd(8'h02, 21'h000010, 8'h00, "R7 program without write enable");
    cmd(8'h06, 21'h0, 8'h00, "R2 set write enable");
    cmd(8'h02, 21'h000010, 8'h00, "R6 level 111 protects address 0");
    cmd(8'h05, 21'h0, 8'h00, "R3 unrelated command breaks arming");
    cmd(8'h01, 21'h0, 8'h00, "R3 status write without arming");
    cmd(8'h06, 21'h0, 8'h00, "R3 arm by write enable");
    cmd(8'h01, 21'h0, 8'h63, "R4 unwritable data bits ignored");
    cmd(8'h50, 21'h0, 8'h00, "R3 arm by 50h");
    cmd(8'h06, 21'h0, 8'h00, "R3 re-arm by write enable");
    cmd(8'h01, 21'h0, 8'h04, "R3 status write after re-arm");

    // level 001: base 1F0000
    cmd(8'h06, 21'h0, 8'h00, "R2 write enable");
    cmd(8'h02, 21'h1F0000, 8'h00, "R6 level 001 base protected");
    cmd(8'h02, 21'h1EFFFF, 8'h00, "R6 level 001 below base granted");
    cmd(8'h06, 21'h0, 8'h00, "R10 write enable while busy");
    cmd(8'h02, 21'h000000, 8'h00, "R10 program refused while busy");
    cmd(8'h01, 21'h0, 8'h00, "R10 status write refused while busy");
    finishOp("R10 completion clears busy and write enable");

    // level 101: base 100000
    cmd(8'h50, 21'h0, 8'h00, "R3 arm");
    cmd(8'h01, 21'h0, 8'h14, "R6 set level 101");
    cmd(8'h06, 21'h0, 8'h00, "R2 write enable");
    cmd(8'h20, 21'h0FF123, 8'h00, "R8 sector below base granted");
    finishOp("R10 completion");
    cmd(8'h06, 21'h0, 8'h00, "R2 write enable");
    cmd(8'h20, 21'h100ABC, 8'h00, "R8 sector at base refused");
    cmd(8'hD8, 21'h0F1234, 8'h00, "R8 block below base granted");
    finishOp("R10 completion");

    // level 100: base 180000
    cmd(8'h50, 21'h0, 8'h00, "R3 arm");
    cmd(8'h01, 21'h0, 8'h10, "R6 set level 100");
    cmd(8'h06, 21'h0, 8'h00, "R2 write enable");
    cmd(8'hD8, 21'h18FFFF, 8'h00, "R8 block in protected range refused");
    cmd(8'h20, 21'h17FFFF, 8'h00, "R8 sector low bits ignored granted");
    finishOp("R10 completion");
    cmd(8'h06, 21'h0, 8'h00, "R2 write enable");
    cmd(8'h60, 21'h0, 8'h00, "R9 chip erase refused at level 100");
    cmd(8'h50, 21'h0, 8'h00, "R3 arm");
    cmd(8'h01, 21'h0, 8'h0C, "R6 set level 011");
    cmd(8'h06, 21'h0, 8'h00, "R2 write enable");
    cmd(8'h02, 21'h1C0000, 8'h00, "R6 level 011 base protected");
    cmd(8'h02, 21'h1BFFFF, 8'h00, "R6 level 011 below base granted");
    finishOp("R10 completion");
    cmd(8'h50, 21'h0, 8'h00, "R3 arm");
    cmd(8'h01, 21'h0, 8'h00, "R6 clear level");
    cmd(8'h06, 21'h0, 8'h00, "R2 write enable");
    cmd(8'hC7, 21'h0, 8'h00, "R9 chip erase granted at level 000");
    finishOp("R10 completion after chip erase");

    // lock-down
    wrProtN = 0;
    cmd(8'h50, 21'h0, 8'h00, "R3 arm");
    cmd(8'h01, 21'h0, 8'h88, "R5 set lock-down and level together");
    cmd(8'h50, 21'h0, 8'h00, "R3 arm");
    cmd(8'h01, 21'h0, 8'h00, "R5 locked status write ignored");
    wrProtN = 1;
    cmd(8'h06, 21'h0, 8'h00, "R3 arm by write enable");
    cmd(8'h01, 21'h0, 8'h04, "R5 input high clears lock-down");

    // word stream up to protected base (level 001)
    cmd(8'h06, 21'h0, 8'h00, "R2 write enable");
    cmd(8'hAD, 21'h1EFFFB, 8'h00, "R11 first word aligned");
    finishOp("R11 completion keeps write enable");
    cmd(8'h02, 21'h000000, 8'h00, "R11 byte program refused in word mode");
    cmd(8'hAD, 21'h000000, 8'h00, "R11 next word address");
    finishOp("R11 completion");
    cmd(8'hAD, 21'h000000, 8'h00, "R11 last word below base");
    finishOp("R12 exit at protected base");
    cmd(8'hAD, 21'h000000, 8'h00, "R7 word refused after exit");

    cmd(8'h06, 21'h0, 8'h00, "R2 write enable");
    cmd(8'hAD, 21'h000100, 8'h00, "R11 start word stream");
    finishOp("R11 completion");
    cmd(8'h04, 21'h0, 8'h00, "R2 disable ends word stream");

    // word stream at the top of an unprotected array
    cmd(8'h06, 21'h0, 8'h00, "R3 arm");
    cmd(8'h01, 21'h0, 8'h00, "R6 clear level");
    cmd(8'h06, 21'h0, 8'h00, "R2 write enable");
    cmd(8'hAD, 21'h1FFFFE, 8'h00, "R11 top word granted");
    finishOp("R12 exit past top of array");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule